// File: doc/BRIEF.md
# Precise Exception Ordering Unit

This unit shadows a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) and decides which fault is taken, and when. Any stage may report a fault for the instruction it holds in a cycle by raising a per-stage strobe with a 3-bit cause. The report is not acted on right away. It is stored with that instruction and travels down the pipe with it. The decision is made only when the instruction reaches writeback, which is the commit point. Faults are therefore taken in program order: an older instruction that faults late in memory still wins over a younger instruction that faulted earlier in time during fetch.

When a flagged instruction reaches commit, it does not commit. In that same cycle the unit asserts a kill for every stage that holds a valid instruction, so the faulting instruction and all younger ones are squashed. One cycle later it raises a single-cycle redirect and presents the faulting PC and cause. These are held until the next trap. Instructions enter through a valid/ready pair. The unit never stalls a transfer except during a flush. A transfer happens only in a cycle where both `in_valid` and `in_ready` are high. While `in_ready` is low, the source must hold its instruction and offer it again later. Fault strobes and outputs are plain control pins.

Top module: `exc_order_unit`

## Requirements
- R1: An instruction is accepted only in a cycle where both `in_valid` and `in_ready` are high. `in_ready` is low in the cycle a trap is taken and in the following redirect cycle, and high in every other cycle.
- R2: An instruction accepted in cycle k that carries no fault asserts `commit_valid` with its PC on `commit_pc` during cycle k+5.
- R3: A strobe `flt_strobe[s]` flags the instruction that occupies stage s (0 = fetch, 1 = decode, 2 = execute, 3 = memory, 4 = writeback) in that cycle. Nothing happens until that instruction reaches writeback, and a flagged instruction never asserts `commit_valid`.
- R4: In the cycle a flagged instruction reaches writeback, `kill[s]` is high for each stage s that holds a valid instruction, and `kill` is zero in every other cycle.
- R5: When several instructions in flight are flagged, the trap is taken for the oldest one, whatever the order in which the faults were reported.
- R6: When one instruction is flagged in more than one stage, the cause reported on the lowest-numbered (earliest) stage is the one that is kept.
- R7: One cycle after a trap, `redirect` is high for exactly one cycle, and `epc` and `ecause` show the faulting PC and cause. Both keep their values until the next trap.
- R8: A strobe on a stage that holds a bubble (no valid instruction) has no effect.
- R9: Strobes that arrive during a flush (the trap cycle or the redirect cycle) are discarded and cause no later trap.
- R10: After reset, all stages are empty, `redirect`, `epc`, `ecause`, `kill` and `commit_valid` are zero, and `in_ready` is high. A reset during operation discards any pending fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is offered to fetch |
| in_ready | output | 1 | Fetch can accept the offered instruction |
| in_pc | input | PC_W | PC of the offered instruction |
| flt_strobe | input | NUM_STAGES | Per-stage fault report, bit s = stage s |
| flt_cause | input | NUM_STAGES*CAUSE_W | Per-stage cause, stage s at bits [s*CAUSE_W +: CAUSE_W] |
| commit_valid | output | 1 | The writeback instruction commits this cycle |
| commit_pc | output | PC_W | PC of the writeback instruction |
| kill | output | NUM_STAGES | Per-stage squash, bit s = stage s |
| redirect | output | 1 | One-cycle trap redirect request |
| epc | output | PC_W | PC of the last trapped instruction |
| ecause | output | CAUSE_W | Cause of the last trapped instruction |

## Verification
`in_ready`, `commit_valid`, `commit_pc` and `kill` are combinational. They are due in the same cycle as the stimulus that sets them: the instruction reaches writeback five clock edges after it is accepted, and a writeback strobe takes effect at once. `redirect`, `epc` and `ecause` are due one edge after the trap cycle. Each row of the stimulus table is driven just after a falling edge, and every output is sampled half a phase later, before the next rising edge. As a result, every expected value in a row holds the combinational results for that cycle and the registered results of the previous cycle's trap.

// File: rtl/exc_order_pkg.sv
package exc_order_pkg;

  localparam int unsigned DEF_STAGES  = 5;
  localparam int unsigned DEF_PC_W    = 32;
  localparam int unsigned DEF_CAUSE_W = 3;

  // Stage positions; the commit point is always the last stage.
  typedef enum int unsigned {
    STG_FETCH  = 0,
    STG_DECODE = 1,
    STG_EXEC   = 2,
    STG_MEM    = 3,
    STG_WBACK  = 4
  } stage_e;

endpackage

// File: rtl/exc_order_slot.sv
// One pipeline position: holds the instruction's valid bit, PC and the
// status vector it has gathered so far, and merges this stage's report.
module exc_order_slot #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned CAUSE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               d_valid,
  input  logic [PC_W-1:0]    d_pc,
  input  logic               d_exc,
  input  logic [CAUSE_W-1:0] d_cause,
  input  logic               flt,
  input  logic [CAUSE_W-1:0] flt_cause,
  output logic               q_valid,
  output logic [PC_W-1:0]    q_pc,
  output logic               m_exc,
  output logic [CAUSE_W-1:0] m_cause
);

  logic               q_exc;
  logic [CAUSE_W-1:0] q_cause;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_pc    <= '0;
      q_exc   <= 1'b0;
      q_cause <= '0;
    end else if (flush) begin
      q_valid <= 1'b0;
      q_exc   <= 1'b0;
      q_cause <= '0;
    end else begin
      q_valid <= d_valid;
      q_pc    <= d_pc;
      q_exc   <= d_valid & d_exc;
      q_cause <= d_valid ? d_cause : '0;
    end
  end

  // A bubble never picks up a report; an earlier recorded cause is kept.
  always_comb begin
    m_exc   = 1'b0;
    m_cause = '0;
    if (q_valid) begin
      if (q_exc) begin
        m_exc   = 1'b1;
        m_cause = q_cause;
      end else if (flt) begin
        m_exc   = 1'b1;
        m_cause = flt_cause;
      end
    end
  end

endmodule

// File: rtl/exc_order_commit.sv
// Commit decision at the last stage: either retire cleanly or trap and
// squash every occupied stage.
module exc_order_commit #(
  parameter int unsigned NUM_STAGES = 5,
  parameter int unsigned PC_W       = 32,
  parameter int unsigned CAUSE_W    = 3
) (
  input  logic [NUM_STAGES-1:0] occ,
  input  logic                  wb_exc,
  input  logic [PC_W-1:0]       wb_pc,
  input  logic [CAUSE_W-1:0]    wb_cause,
  output logic                  commit_valid,
  output logic [PC_W-1:0]       commit_pc,
  output logic                  trap,
  output logic [PC_W-1:0]       trap_pc,
  output logic [CAUSE_W-1:0]    trap_cause,
  output logic [NUM_STAGES-1:0] kill
);

  localparam int unsigned LAST = NUM_STAGES - 1;

  always_comb begin
    trap         = occ[LAST] & wb_exc;
    commit_valid = occ[LAST] & ~wb_exc;
    commit_pc    = wb_pc;
    trap_pc      = wb_pc;
    trap_cause   = wb_cause;
    kill         = trap ? occ : '0;
  end

endmodule

// File: rtl/exc_order_trap_reg.sv
// Exception PC / cause holding registers and the one-cycle redirect pulse.
module exc_order_trap_reg #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned CAUSE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap,
  input  logic [PC_W-1:0]    trap_pc,
  input  logic [CAUSE_W-1:0] trap_cause,
  output logic               redirect,
  output logic [PC_W-1:0]    epc,
  output logic [CAUSE_W-1:0] ecause
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect <= 1'b0;
      epc      <= '0;
      ecause   <= '0;
    end else begin
      redirect <= trap;
      if (trap) begin
        epc    <= trap_pc;
        ecause <= trap_cause;
      end
    end
  end

endmodule

// File: rtl/exc_order_unit.sv
module exc_order_unit
  import exc_order_pkg::*;
#(
  parameter int unsigned NUM_STAGES = DEF_STAGES,
  parameter int unsigned PC_W       = DEF_PC_W,
  parameter int unsigned CAUSE_W    = DEF_CAUSE_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [PC_W-1:0]               in_pc,
  input  logic [NUM_STAGES-1:0]         flt_strobe,
  input  logic [NUM_STAGES*CAUSE_W-1:0] flt_cause,
  output logic                          commit_valid,
  output logic [PC_W-1:0]               commit_pc,
  output logic [NUM_STAGES-1:0]         kill,
  output logic                          redirect,
  output logic [PC_W-1:0]               epc,
  output logic [CAUSE_W-1:0]            ecause
);

  localparam int unsigned LAST = NUM_STAGES - 1;

  logic [NUM_STAGES-1:0] q_valid;
  logic [NUM_STAGES-1:0] m_exc;
  logic [NUM_STAGES-1:0] flt_eff;
  logic [PC_W-1:0]       q_pc    [NUM_STAGES];
  logic [CAUSE_W-1:0]    m_cause [NUM_STAGES];

  logic               trap;
  logic [PC_W-1:0]    trap_pc;
  logic [CAUSE_W-1:0] trap_cause;

  // Reports made during the redirect cycle are dropped; those made in the
  // trap cycle die with the flush of their slots.
  assign flt_eff  = flt_strobe & {NUM_STAGES{~redirect}};
  assign in_ready = ~trap & ~redirect;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_slot
    logic               d_valid;
    logic [PC_W-1:0]    d_pc;
    logic               d_exc;
    logic [CAUSE_W-1:0] d_cause;

    if (s == int'(STG_FETCH)) begin : g_entry
      assign d_valid = in_valid & in_ready;
      assign d_pc    = in_pc;
      assign d_exc   = 1'b0;
      assign d_cause = '0;
    end else begin : g_chain
      assign d_valid = q_valid[s-1];
      assign d_pc    = q_pc[s-1];
      assign d_exc   = m_exc[s-1];
      assign d_cause = m_cause[s-1];
    end

    exc_order_slot #(
      .PC_W   (PC_W),
      .CAUSE_W(CAUSE_W)
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (trap),
      .d_valid  (d_valid),
      .d_pc     (d_pc),
      .d_exc    (d_exc),
      .d_cause  (d_cause),
      .flt      (flt_eff[s]),
      .flt_cause(flt_cause[s*CAUSE_W +: CAUSE_W]),
      .q_valid  (q_valid[s]),
      .q_pc     (q_pc[s]),
      .m_exc    (m_exc[s]),
      .m_cause  (m_cause[s])
    );
  end

  exc_order_commit #(
    .NUM_STAGES(NUM_STAGES),
    .PC_W      (PC_W),
    .CAUSE_W   (CAUSE_W)
  ) u_commit (
    .occ         (q_valid),
    .wb_exc      (m_exc[LAST]),
    .wb_pc       (q_pc[LAST]),
    .wb_cause    (m_cause[LAST]),
    .commit_valid(commit_valid),
    .commit_pc   (commit_pc),
    .trap        (trap),
    .trap_pc     (trap_pc),
    .trap_cause  (trap_cause),
    .kill        (kill)
  );

  exc_order_trap_reg #(
    .PC_W   (PC_W),
    .CAUSE_W(CAUSE_W)
  ) u_trap (
    .clk       (clk),
    .rst_n     (rst_n),
    .trap      (trap),
    .trap_pc   (trap_pc),
    .trap_cause(trap_cause),
    .redirect  (redirect),
    .epc       (epc),
    .ecause    (ecause)
  );

endmodule

// File: rtl/exc_order_checks.sv
module exc_order_checks #(
  parameter int unsigned NUM_STAGES = 5,
  parameter int unsigned PC_W       = 32,
  parameter int unsigned CAUSE_W    = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_ready,
  input logic                  commit_valid,
  input logic [NUM_STAGES-1:0] kill,
  input logic                  redirect,
  input logic [PC_W-1:0]       epc,
  input logic [CAUSE_W-1:0]    ecause
);

  localparam int unsigned LAST = NUM_STAGES - 1;

  assert_flush_blocks_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (kill[LAST] || redirect) |-> !in_ready);

  assert_flagged_never_commits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    kill[LAST] |-> !commit_valid);

  assert_kill_only_on_trap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|kill) |-> kill[LAST]);

  assert_redirect_follows_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    kill[LAST] |=> redirect);

  assert_redirect_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !redirect);

  assert_trap_info_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |-> ($stable(epc) && $stable(ecause)));

  assert_quiet_during_redirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> ((kill == '0) && !commit_valid));

endmodule

bind exc_order_unit exc_order_checks #(
  .NUM_STAGES(NUM_STAGES),
  .PC_W      (PC_W),
  .CAUSE_W   (CAUSE_W)
) u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .commit_valid(commit_valid),
  .kill        (kill),
  .redirect    (redirect),
  .epc         (epc),
  .ecause      (ecause)
);

// File: tb/test_exc_order_unit.sv
module test_exc_order_unit;

  localparam int unsigned NS  = 5;
  localparam int unsigned PW  = 32;
  localparam int unsigned CW  = 3;

  typedef struct packed {
    logic        iv;
    logic [7:0]  pc;
    logic [4:0]  fm;     // strobe per stage, bit s = stage s
    logic [14:0] fc;     // cause of stage s at [3s+:3]
    logic        rdy;
    logic        cv;
    logic [7:0]  cpc;
    logic [4:0]  kl;
    logic        rd;
    logic [7:0]  epc;
    logic [2:0]  ec;
    logic [3:0]  tag;    // requirement number for the trap-info checks
  } row_t;

  localparam int NROWS = 37;
  localparam row_t TBL [NROWS] = '{
    // fill the pipe with clean instructions (R2)
    '{1'b1, 8'h10, 5'b00000, 15'h0000, 1'b1, 1'b0, 8'h00, 5'b00000, 1'b0, 8'h00, 3'd0, 4'd10},
    '{1'b1, 8'h11, 5'b00000, 15'h0000, 1'b1, 1'b0, 8'h00, 5'b00000, 1'b0, 8'h00, 3'd0, 4'd10},
    '{1'b1, 8'h12, 5'b00000, 15'h0000, 1'b1, 1'b0, 8'h00, 5'b00000, 1'b0, 8'h00, 3'd0, 4'd10},
    '{1'b1, 8'h13, 5'b00000, 15'h0000, 1'b1, 1'b0, 8'h00, 5'b00000, 1'b0, 8'h00, 3'd0, 4'd10},
    '{1'b1, 8'h14, 5'b00000, 15'h0000, 1'b1, 1'b0, 8'h00, 5'b00000, 1'b0, 8'h00, 3'd0, 4'd10},
    // 10 commits; memory fault (cause 5) on 11 and fetch fault (cause 1) on 14 together (R3, R5)
    '{1'b1, 8'h15, 5'b01001, 15'h0A01, 1'b1, 1'b1, 8'h10, 5'b00000, 1'b0, 8'h00, 3'd0, 4'd3},
    // 11 traps, whole pipe killed; strobe on execute is moot (R4)
    '{1'b1, 8'h16, 5'b00100, 15'h01C0, 1'b0, 1'b0, 8'h00, 5'b11111, 1'b0, 8'h00, 3'd0, 4'd4},
    // redirect cycle: oldest wins, writeback strobe is discarded (R5, R9)
    '{1'b1, 8'h17, 5'b10000, 15'h3000, 1'b0, 1'b0, 8'h00, 5'b00000, 1'b1, 8'h11, 3'd5, 4'd5},
    '{1'b1, 8'h20, 5'b00000, 15'h0000, 1'b1, 1'b0, 8'h00, 5'b00000, 1'b0, 8'h11, 3'd5, 4'd9},
    // fetch fault cause 1 on 20
    '{1'b1, 8'h21, 5'b00001, 15'h0001, 1'b1, 1'b0, 8'h00, 5'b00000, 1'b0, 8'h11, 3'd5, 4'd9},
    '{1'b1, 8'h22, 5'b00000, 15'h0000, 1'b1, 1'b0, 8'h00, 5'b00000, 1'b0, 8'h11, 3'd5, 4'd9},
    '{1'b0, 8'h00, 5'b00000, 15'h0000, 1'b1, 1'b0, 8'h00, 5'b00000, 1'b0, 8'h11, 3'd5, 4'd9},
    // second fault cause 6 on 20 in memory (R6); strobe on fetch bubble (R8)
    '{1'b0, 8'h00, 5'b01001, 15'h0C04, 1'b1, 1'b0, 8'h00, 5'b00000, 1'b0, 8'h11, 3'd5, 4'd8},
    '{1'b0, 8'h00, 5'b00000, 15'h0000, 1'b0, 1'b0, 8'h00, 5'b11100, 1'b0, 8'h11, 3'd5, 4'd4},
    '{1'b0, 8'h00, 5'b00000, 15'h0000, 1'b0, 1'b0, 8'h00, 5'b00000, 1'b1, 8'h20, 3'd1, 4'd6},
    '{1'b1, 8'h30, 5'b00000, 15'h0000, 1'b1, 1'b0, 8'h00, 5'b00000, 1'b0, 8'h20, 3'd1, 4'd7},
    '{1'b1, 8'h31, 5'b00000, 15'h0000, 1'b1, 1'b0, 8'h00, 5'b00000, 1'b0, 8'h20, 3'd1, 4'd7},
    // younger 31 faults early in fetch (cause 2)
    '{1'b0, 8'h00, 5'b00001, 15'h0002, 1'b1, 1'b0, 8'h00, 5'b00000, 1'b0, 8'h20, 3'd1, 4'd7},
    '{1'b0, 8'h00, 5'b00000, 15'h0000, 1'b1, 1'b0, 8'h00, 5'b00000, 1'b0, 8'h20, 3'd1, 4'd7},
    // older 30 faults later in memory (cause 4)
    '{1'b0, 8'h00, 5'b01000, 15'h0800, 1'b1, 1'b0, 8'h00, 5'b00000, 1'b0, 8'h20, 3'd1, 4'd7},
    '{1'b0, 8'h00, 5'b00000, 15'h0000, 1'b0, 1'b0, 8'h00, 5'b11000, 1'b0, 8'h20, 3'd1, 4'd4},
    // R5: the older late fault wins
    '{1'b0, 8'h00, 5'b00000, 15'h0000, 1'b0, 1'b0, 8'h00, 5'b00000, 1'b1, 8'h30, 3'd4, 4'd5},
    '{1'b1, 8'h40, 5'b00000, 15'h0000, 1'b1, 1'b0, 8'h00, 5'b00000, 1'b0, 8'h30, 3'd4, 4'd7},
    '{1'b0, 8'h00, 5'b00000, 15'h0000, 1'b1, 1'b0, 8'h00, 5'b00000, 1'b0, 8'h30, 3'd4, 4'd7},
    '{1'b0, 8'h00, 5'b00000, 15'h0000, 1'b1, 1'b0, 8'h00, 5'b00000, 1'b0, 8'h30, 3'd4, 4'd7},
    '{1'b0, 8'h00, 5'b00000, 15'h0000, 1'b1, 1'b0, 8'h00, 5'b00000, 1'b0, 8'h30, 3'd4, 4'd7},
    '{1'b0, 8'h00, 5'b00000, 15'h0000, 1'b1, 1'b0, 8'h00, 5'b00000, 1'b0, 8'h30, 3'd4, 4'd7},
    // fault raised in writeback itself traps the same cycle (R3, R4)
    '{1'b0, 8'h00, 5'b10000, 15'h3000, 1'b0, 1'b0, 8'h00, 5'b10000, 1'b0, 8'h30, 3'd4, 4'd4},
    '{1'b0, 8'h00, 5'b00000, 15'h0000, 1'b0, 1'b0, 8'h00, 5'b00000, 1'b1, 8'h40, 3'd3, 4'd7},
    '{1'b1, 8'h50, 5'b00000, 15'h0000, 1'b1, 1'b0, 8'h00, 5'b00000, 1'b0, 8'h40, 3'd3, 4'd7},
    '{1'b1, 8'h51, 5'b00000, 15'h0000, 1'b1, 1'b0, 8'h00, 5'b00000, 1'b0, 8'h40, 3'd3, 4'd7},
    '{1'b0, 8'h00, 5'b00000, 15'h0000, 1'b1, 1'b0, 8'h00, 5'b00000, 1'b0, 8'h40, 3'd3, 4'd7},
    '{1'b0, 8'h00, 5'b00000, 15'h0000, 1'b1, 1'b0, 8'h00, 5'b00000, 1'b0, 8'h40, 3'd3, 4'd7},
    '{1'b0, 8'h00, 5'b00000, 15'h0000, 1'b1, 1'b0, 8'h00, 5'b00000, 1'b0, 8'h40, 3'd3, 4'd7},
    '{1'b0, 8'h00, 5'b00000, 15'h0000, 1'b1, 1'b1, 8'h50, 5'b00000, 1'b0, 8'h40, 3'd3, 4'd2},
    '{1'b0, 8'h00, 5'b00000, 15'h0000, 1'b1, 1'b1, 8'h51, 5'b00000, 1'b0, 8'h40, 3'd3, 4'd2},
    '{1'b0, 8'h00, 5'b00000, 15'h0000, 1'b1, 1'b0, 8'h00, 5'b00000, 1'b0, 8'h40, 3'd3, 4'd2}
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic [PW-1:0]      in_pc = '0;
  logic [NS-1:0]      flt_strobe = '0;
  logic [NS*CW-1:0]   flt_cause = '0;
  logic               commit_valid;
  logic [PW-1:0]      commit_pc;
  logic [NS-1:0]      kill;
  logic               redirect;
  logic [PW-1:0]      epc;
  logic [CW-1:0]      ecause;

  int n_chk  = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  exc_order_unit #(.NUM_STAGES(NS), .PC_W(PW), .CAUSE_W(CW)) i_exc_order_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_pc(in_pc),
    .flt_strobe(flt_strobe), .flt_cause(flt_cause), .commit_valid(commit_valid),
    .commit_pc(commit_pc), .kill(kill), .redirect(redirect), .epc(epc), .ecause(ecause)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL R10 watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    #5;
    // R10: reset state
    chk("R10", "in_ready", {31'd0, in_ready}, 32'd1);
    chk("R10", "redirect", {31'd0, redirect}, 32'd0);
    chk("R10", "epc", epc, 32'd0);
    chk("R10", "kill", {27'd0, kill}, 32'd0);
    chk("R10", "commit_valid", {31'd0, commit_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < NROWS; k++) begin
      string tg;
      in_valid   = TBL[k].iv;
      in_pc      = {24'd0, TBL[k].pc};
      flt_strobe = TBL[k].fm;
      flt_cause  = TBL[k].fc;
      #5;
      tg = $sformatf("R%0d row%0d", TBL[k].tag, k);
      chk("R1", "in_ready", {31'd0, in_ready}, {31'd0, TBL[k].rdy});
      chk("R2", "commit_valid", {31'd0, commit_valid}, {31'd0, TBL[k].cv});
      if (TBL[k].cv) chk("R2", "commit_pc", commit_pc, {24'd0, TBL[k].cpc});
      chk("R4", "kill", {27'd0, kill}, {27'd0, TBL[k].kl});
      chk("R7", "redirect", {31'd0, redirect}, {31'd0, TBL[k].rd});
      chk(tg, "epc", epc, {24'd0, TBL[k].epc});
      chk(tg, "ecause", {29'd0, ecause}, {29'd0, TBL[k].ec});
      @(negedge clk);
    end
    // R10: reset mid-flight drops a pending fetch fault
    in_valid = 1'b1; in_pc = 32'h60; flt_strobe = '0; flt_cause = '0;
    @(negedge clk);
    in_valid = 1'b0; flt_strobe = 5'b00001; flt_cause = 15'h0005;
    @(negedge clk);
    flt_strobe = '0;
    rst_n = 1'b0;
    #5;
    chk("R10", "epc in reset", epc, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      #5;
      chk("R10", "kill after reset", {27'd0, kill}, 32'd0);
      chk("R10", "redirect after reset", {31'd0, redirect}, 32'd0);
      @(negedge clk);
    end
    chk("R10", "ecause after reset", {29'd0, ecause}, 32'd0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule